// File: doc/BRIEF.md
# Masked packed float-to-unsigned converter

This block takes a vector of up to sixteen 32-bit lanes, each holding an IEEE-754 single-precision value, and turns every lane into a 32-bit unsigned integer. Any fraction is dropped, so the result is rounded toward zero. A lane whose value has no unsigned 32-bit representation saturates to all ones and raises the invalid flag. A lane that loses a nonzero fraction raises the inexact flag. A vector-length select sets how many lanes are active. Every destination bit above the active length is driven to zero.

A write mask controls each lane. A lane that the mask disables either keeps the prior destination value, which the caller supplies on `old_dst`, or is cleared, depending on the zeroing control. A broadcast control feeds source bits [31:0] to every active lane. The conversion is combinational and feeds one output register stage. The block captures its inputs on a cycle with `in_valid` high and presents the result with `out_valid` one clock later.

The output stage is a two-state machine. OS_IDLE means no fresh result is present. OS_DONE means the registers hold a result captured on the previous edge. The CAPTURE transition (OS_IDLE→OS_DONE, or OS_DONE→OS_DONE) happens on any cycle with `in_valid` high. The DRAIN transition (OS_DONE→OS_IDLE) happens on a cycle with `in_valid` low. Synchronous reset forces OS_IDLE.

Top module: `pack_f2u_trunc`

## Requirements
- R1: A finite lane value v with 0 ≤ v < 2^32 yields floor(v) as an unsigned 32-bit integer in bits [32j+31:32j] of `dst` for lane j.
- R2: A lane holding NaN, ±infinity, a value ≥ 2^32 or a value ≤ −1.0 yields 0xFFFFFFFF and sets `flag_invalid`.
- R3: Negative values above −1.0 and ±0.0 yield 0. Denormals of either sign yield 0 and set `flag_inexact`. −0.0 and +0.0 do not set it.
- R4: `flag_inexact` is set exactly when some enabled lane discards a nonzero fraction. It is clear when every enabled lane converts exactly.
- R5: `vlen_sel` 0, 1, 2 gives 4, 8, 16 active lanes, and code 3 also gives 16. Bits of `dst` at and above 128 × (active lanes / 4) are zero.
- R6: With `mask_en` low every active lane is written. With `mask_en` high, active lane j is written only when `lane_mask[j]` is 1.
- R7: With `zero_mode` low, an active lane that the mask disables takes the value of the same lane of `old_dst`.
- R8: With `zero_mode` high, an active lane that the mask disables is 0.
- R9: With `bcast` high, every active written lane converts `src[31:0]`. Other source lanes have no effect.
- R10: The flags are the OR over active, mask-enabled lanes only. Invalid or inexact values in disabled or inactive lanes set no flag.
- R11: `out_valid` is high exactly on the cycle after a cycle with `in_valid` high. While `in_valid` is low, `dst` and the flags hold their values.
- R12: Synchronous reset clears `dst`, both flags and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for all inputs |
| vlen_sel | input | 2 | Active length: 0=4 lanes, 1=8, 2 or 3=16 |
| mask_en | input | 1 | 1 applies `lane_mask`, 0 writes every active lane |
| zero_mode | input | 1 | For disabled lanes: 1 clears, 0 keeps `old_dst` |
| bcast | input | 1 | 1 feeds `src[31:0]` to every lane |
| lane_mask | input | 16 | Per-lane write enable |
| src | input | 512 | Packed single-precision source lanes |
| old_dst | input | 512 | Prior destination, used for merging |
| out_valid | output | 1 | Result registers hold a fresh result |
| dst | output | 512 | Packed unsigned results |
| flag_invalid | output | 1 | Some enabled lane was out of range or NaN |
| flag_inexact | output | 1 | Some enabled lane dropped a nonzero fraction |

## Verification
Assertions checked on every cycle cover the timing of `out_valid` after each strobe and the holding of `dst` while idle. They also check the zeroing of the upper half and more for the 128-bit length, and that flags stay clear under an all-zero mask. Inside each lane they check that an enabled invalid lane shows all ones, and that a disabled lane shows either zero or its merge value. The numeric values themselves can only be shown by the bench's scenarios. These cover truncation at the 2^31 and 2^32 edges, negatives just above −1.0, signed zeros and denormals, broadcast, and flag filtering by mask and length. The bench compares each result against a real-number model.

// File: rtl/f2u_pkg.sv
package f2u_pkg;

    typedef enum logic [1:0] {
        VL_4   = 2'd0,
        VL_8   = 2'd1,
        VL_16  = 2'd2,
        VL_16B = 2'd3
    } vlen_e;

    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_DONE = 1'b1
    } ostate_e;

    typedef struct packed {
        logic [31:0] val;
        logic        inv;
        logic        inx;
    } cvt_res_t;

    // lanes enabled by a length code, clipped to the lanes built
    function automatic int unsigned lanes_for(input logic [1:0] code, input int unsigned max_lanes);
        int unsigned n;
        case (code)
            2'd0:    n = 4;
            2'd1:    n = 8;
            default: n = 16;
        endcase
        return (n > max_lanes) ? max_lanes : n;
    endfunction

endpackage

// File: rtl/f2u_lane_cvt.sv
module f2u_lane_cvt
    import f2u_pkg::*;
(
    input  logic [31:0] fp_i,
    output cvt_res_t    res_o
);
    logic        sgn;
    logic [7:0]  ex;
    logic [22:0] fr;
    logic [4:0]  shamt;
    logic [54:0] ext;

    assign sgn = fp_i[31];
    assign ex  = fp_i[30:23];
    assign fr  = fp_i[22:0];

    // For biased exponent 127..158, (ex - 127) mod 32 equals ex[4:0] + 1
    assign shamt = ex[4:0] + 5'd1;
    assign ext   = {31'd0, 1'b1, fr} << shamt;

    always_comb begin
        res_o = '0;
        if (ex == 8'hFF) begin
            res_o.val = '1;
            res_o.inv = 1'b1;
        end else if (ex == 8'h00) begin
            res_o.inx = |fr;
        end else if (ex < 8'd127) begin
            res_o.inx = 1'b1;
        end else if (sgn || ex >= 8'd159) begin
            res_o.val = '1;
            res_o.inv = 1'b1;
        end else begin
            res_o.val = ext[54:23];
            res_o.inx = |ext[22:0];
        end
    end

    always_comb begin
        if (res_o.inv) begin
            assert_inv_excl_R2: assert (!res_o.inx && res_o.val == 32'hFFFF_FFFF);
        end
    end
endmodule

// File: rtl/f2u_lane_ctl.sv
module f2u_lane_ctl
    import f2u_pkg::*;
#(
    parameter int unsigned IDX   = 0,
    parameter int unsigned CNT_W = 5
) (
    input  logic [CNT_W-1:0] act_cnt_i,
    input  logic             mask_en_i,
    input  logic             zero_mode_i,
    input  logic             mask_bit_i,
    input  cvt_res_t         cvt_i,
    input  logic [31:0]      old_i,
    output logic [31:0]      lane_o,
    output logic             inv_o,
    output logic             inx_o
);
    logic active;
    logic wr_en;

    assign active = (CNT_W'(IDX) < act_cnt_i);
    assign wr_en  = active && (!mask_en_i || mask_bit_i);

    always_comb begin
        if (!active)          lane_o = '0;
        else if (wr_en)       lane_o = cvt_i.val;
        else if (zero_mode_i) lane_o = '0;
        else                  lane_o = old_i;
    end

    assign inv_o = wr_en && cvt_i.inv;
    assign inx_o = wr_en && cvt_i.inx;

    always_comb begin
        if (wr_en && cvt_i.inv) begin
            assert_sat_R2: assert (lane_o == 32'hFFFF_FFFF);
        end
        if (active && !wr_en && zero_mode_i) begin
            assert_zeroing_R8: assert (lane_o == 32'd0 && !inv_o && !inx_o);
        end
        if (active && !wr_en && !zero_mode_i) begin
            assert_merge_R7: assert (lane_o == old_i);
        end
    end
endmodule

// File: rtl/pack_f2u_trunc.sv
module pack_f2u_trunc
    import f2u_pkg::*;
#(
    parameter int unsigned MAX_LANES = 16,
    parameter int unsigned LANE_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [1:0]                    vlen_sel,
    input  logic                          mask_en,
    input  logic                          zero_mode,
    input  logic                          bcast,
    input  logic [MAX_LANES-1:0]          lane_mask,
    input  logic [MAX_LANES*LANE_W-1:0]   src,
    input  logic [MAX_LANES*LANE_W-1:0]   old_dst,
    output logic                          out_valid,
    output logic [MAX_LANES*LANE_W-1:0]   dst,
    output logic                          flag_invalid,
    output logic                          flag_inexact
);
    localparam int unsigned VEC_W   = MAX_LANES * LANE_W;
    localparam int unsigned CNT_W   = $clog2(MAX_LANES) + 1;
    localparam int unsigned MIN_VEC = 4 * LANE_W;

    logic [CNT_W-1:0]     act_cnt;
    logic [VEC_W-1:0]     dst_d;
    logic [MAX_LANES-1:0] inv_l;
    logic [MAX_LANES-1:0] inx_l;

    assign act_cnt = CNT_W'(lanes_for(vlen_sel, MAX_LANES));

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        logic [31:0] lane_src;
        cvt_res_t    cvt;

        if (j == 0) begin : g_first
            assign lane_src = src[31:0];
        end else begin : g_rest
            assign lane_src = bcast ? src[31:0] : src[j*LANE_W +: LANE_W];
        end

        f2u_lane_cvt u_cvt (
            .fp_i  (lane_src),
            .res_o (cvt)
        );

        f2u_lane_ctl #(.IDX(j), .CNT_W(CNT_W)) u_ctl (
            .act_cnt_i   (act_cnt),
            .mask_en_i   (mask_en),
            .zero_mode_i (zero_mode),
            .mask_bit_i  (lane_mask[j]),
            .cvt_i       (cvt),
            .old_i       (old_dst[j*LANE_W +: LANE_W]),
            .lane_o      (dst_d[j*LANE_W +: LANE_W]),
            .inv_o       (inv_l[j]),
            .inx_o       (inx_l[j])
        );
    end

    // output stage control
    ostate_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= OS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_IDLE: state_d = in_valid ? OS_DONE : OS_IDLE;
            OS_DONE: state_d = in_valid ? OS_DONE : OS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dst          <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else if (in_valid) begin
            dst          <= dst_d;
            flag_invalid <= |inv_l;
            flag_inexact <= |inx_l;
        end
    end

    assign out_valid = (state_q == OS_DONE);

    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drops_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(dst) && $stable(flag_invalid) && $stable(flag_inexact)));
    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vlen_sel == 2'd0) |=> (dst[VEC_W-1:MIN_VEC] == '0));
    assert_no_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && lane_mask == '0) |=> (!flag_invalid && !flag_inexact));
endmodule

// File: tb/test_pack_f2u_trunc.sv
module test_pack_f2u_trunc;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   vlen_sel;
    logic         mask_en, zero_mode, bcast;
    logic [15:0]  lane_mask;
    logic [511:0] src, old_dst;
    logic         out_valid;
    logic [511:0] dst;
    logic         flag_invalid, flag_inexact;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [511:0] d;
        logic         inv;
        logic         inx;
        string        tag;
    } exp_t;
    exp_t sb[$];
    logic [511:0] last_dst;

    always #5 clk = ~clk;

    pack_f2u_trunc i_pack_f2u_trunc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .vlen_sel(vlen_sel),
        .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
        .lane_mask(lane_mask), .src(src), .old_dst(old_dst),
        .out_valid(out_valid), .dst(dst),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    task automatic chk(input string tag, input string what, input bit ok,
                       input logic [511:0] act, input logic [511:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // real-number model of one lane
    function automatic void ref_lane(input logic [31:0] x, output logic [31:0] r,
                                     output logic inv, output logic inx);
        int  e;
        real v, q;
        e = int'(x[30:23]);
        r = '0; inv = 1'b0; inx = 1'b0;
        if (e == 255) begin r = '1; inv = 1'b1; return; end
        if (e == 0) begin inx = (x[22:0] != 0); return; end
        v = real'(int'({1'b1, x[22:0]}));
        for (int k = 0; k < e - 150; k++) v = v * 2.0;
        for (int k = 0; k < 150 - e; k++) v = v / 2.0;
        if (x[31]) begin
            if (v >= 1.0) begin r = '1; inv = 1'b1; end
            else inx = 1'b1;
            return;
        end
        if (v >= 4294967296.0) begin r = '1; inv = 1'b1; return; end
        q = $floor(v);
        r = 32'(longint'(q));
        inx = (q != v);
    endfunction

    function automatic logic [511:0] setl(input logic [511:0] v, input int j, input logic [31:0] x);
        logic [511:0] t;
        t = v;
        t[j*32 +: 32] = x;
        return t;
    endfunction

    task automatic drive(input logic [1:0] vl, input bit me, input bit zm, input bit bc,
                         input logic [15:0] mk, input logic [511:0] s, input logic [511:0] od,
                         input string tag);
        exp_t e;
        int   nl;
        nl = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
        e.d = '0; e.inv = 1'b0; e.inx = 1'b0; e.tag = tag;
        for (int j = 0; j < 16; j++) begin
            logic [31:0] r, x;
            logic        iv, ix;
            if (j < nl) begin
                if (!me || mk[j]) begin
                    x = bc ? s[31:0] : s[j*32 +: 32];
                    ref_lane(x, r, iv, ix);
                    e.d[j*32 +: 32] = r;
                    e.inv = e.inv | iv;
                    e.inx = e.inx | ix;
                end else if (!zm) begin
                    e.d[j*32 +: 32] = od[j*32 +: 32];
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b1; vlen_sel = vl; mask_en = me; zero_mode = zm; bcast = bc;
        lane_mask = mk; src = s; old_dst = od;
        sb.push_back(e);
        last_dst = e.d;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            src = {16{32'h7FC0_0000}};
        end
    endtask

    // monitor
    always begin
        @(posedge clk);
        #2;
        if (!rst && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    chk("R11", "unexpected out_valid", 1'b0, 512'd1, 512'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.tag, "dst", dst == e.d, dst, e.d);
                    chk(e.tag, "flag_invalid", flag_invalid == e.inv, 512'(flag_invalid), 512'(e.inv));
                    chk(e.tag, "flag_inexact", flag_inexact == e.inx, 512'(flag_inexact), 512'(e.inx));
                end
            end
        end
    end

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [511:0] s, od;
        rst = 1'b1; in_valid = 1'b0; vlen_sel = 2'd0; mask_en = 1'b0; zero_mode = 1'b0;
        bcast = 1'b0; lane_mask = '0; src = '0; old_dst = '0; last_dst = '0;
        repeat (3) @(posedge clk);
        #2;
        chk("R12", "reset dst", dst == '0, dst, '0);
        chk("R12", "reset out_valid/flags", {out_valid, flag_invalid, flag_inexact} == 3'b000,
            512'({out_valid, flag_invalid, flag_inexact}), '0);
        @(negedge clk); rst = 1'b0;

        // R1: in-range truncation, including the 2^31 and just-below-2^32 edges
        s = '0;
        s = setl(s, 0, 32'h3F80_0000);  // 1.0
        s = setl(s, 1, 32'h4070_0000);  // 3.75
        s = setl(s, 2, 32'h4F00_0000);  // 2^31
        s = setl(s, 3, 32'h4F7F_FFFF);  // largest below 2^32
        drive(2'd0, 1'b0, 1'b0, 1'b0, '0, s, '0, "R1");
        // R2: out-of-range and non-numbers
        s = '0;
        s = setl(s, 0, 32'h7FC0_0000); s = setl(s, 1, 32'h7F80_0000);
        s = setl(s, 2, 32'hFF80_0000); s = setl(s, 3, 32'h4F80_0000);
        s = setl(s, 4, 32'hBF80_0000); s = setl(s, 5, 32'hC000_0000);
        drive(2'd1, 1'b0, 1'b0, 1'b0, '0, s, '0, "R2");
        // R3: signed zero, small negatives, denormals
        s = '0;
        s = setl(s, 0, 32'h8000_0000); s = setl(s, 1, 32'hBF7F_FFFF);
        s = setl(s, 2, 32'h0000_0001); s = setl(s, 3, 32'h8040_0000);
        drive(2'd0, 1'b0, 1'b0, 1'b0, '0, s, '0, "R3");
        // R4: exact lanes only, including both zeros
        s = '0;
        s = setl(s, 0, 32'h8000_0000); s = setl(s, 1, 32'h4B80_0001);
        s = setl(s, 2, 32'h4000_0000);
        drive(2'd0, 1'b0, 1'b0, 1'b0, '0, s, '0, "R4");
        idle(3);
        chk("R11", "idle out_valid low", out_valid == 1'b0, 512'(out_valid), '0);
        chk("R11", "dst held while idle", dst == last_dst, dst, last_dst);

        // R5: each length code with every lane nonzero
        s = '0;
        for (int j = 0; j < 16; j++) s = setl(s, j, 32'h4120_0000 + 32'(j << 20));
        for (int v = 0; v < 4; v++) drive(2'(v), 1'b0, 1'b0, 1'b0, '0, s, {16{32'hA5A5_5A5A}}, "R5");
        // R6 and R7: merging under mask
        od = '0;
        for (int j = 0; j < 16; j++) od = setl(od, j, 32'hC0DE_0000 + 32'(j));
        drive(2'd2, 1'b1, 1'b0, 1'b0, 16'hA5C3, s, od, "R6_R7");
        drive(2'd2, 1'b1, 1'b0, 1'b0, 16'h0000, s, od, "R7");
        // R8: zeroing under mask
        drive(2'd2, 1'b1, 1'b1, 1'b0, 16'h3C5A, s, od, "R8");
        // R9: broadcast, other lanes hold NaN
        s = {16{32'h7FC0_0000}};
        s = setl(s, 0, 32'h40B0_0000);  // 5.5
        drive(2'd1, 1'b0, 1'b0, 1'b1, '0, s, od, "R9");
        drive(2'd2, 1'b1, 1'b0, 1'b1, 16'h00F0, s, od, "R9");
        // R10: invalid/inexact only in disabled or inactive lanes
        s = {16{32'h7FC0_0000}};
        s = setl(s, 0, 32'h4000_0000); s = setl(s, 1, 32'h3FC0_0000);
        drive(2'd1, 1'b1, 1'b0, 1'b0, 16'hFF01, s, od, "R10");
        s = {16{32'h3FC0_0000}};
        for (int j = 0; j < 4; j++) s = setl(s, j, 32'h4080_0000);
        drive(2'd0, 1'b0, 1'b1, 1'b0, '0, s, od, "R10");
        idle(2);

        // R12: reset in the middle of operation
        drive(2'd2, 1'b0, 1'b0, 1'b0, '0, {16{32'h4F7F_FFFF}}, '0, "R1");
        idle(3);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2;
        chk("R12", "mid reset dst", dst == '0, dst, '0);
        chk("R12", "mid reset flags/valid", {out_valid, flag_invalid, flag_inexact} == 3'b000,
            512'({out_valid, flag_invalid, flag_inexact}), '0);
        @(negedge clk); rst = 1'b0;

        // mixed sweep, back to back (R11)
        for (int it = 0; it < 60; it++) begin
            logic [511:0] rs, ro;
            rs = '0; ro = '0;
            for (int j = 0; j < 16; j++) begin
                logic [31:0] x;
                x = $urandom;
                case ($urandom % 5)
                    0: x = {1'b0, 8'(127 + ($urandom % 34)), x[22:0]};
                    1: x = {1'b1, 8'(110 + ($urandom % 20)), x[22:0]};
                    2: x = {x[31], 8'd0, x[22:0]};
                    3: x = {1'b0, 8'(150 + ($urandom % 8)), x[22:0]};
                    default: ;
                endcase
                rs = setl(rs, j, x);
                ro = setl(ro, j, $urandom);
            end
            drive(2'($urandom), 1'($urandom), 1'($urandom), 1'(($urandom % 4) == 0),
                  16'($urandom), rs, ro, "R11");
        end
        idle(4);
        chk("R11", "scoreboard drained", sb.size() == 0, 512'(sb.size()), '0);
        finish_up();
    end
endmodule